// File: doc/BRIEF.md
# Execute Stage ALU with Branch Resolution

This block is the execute stage of a small 32-bit in-order core. Each cycle in which its input token is set, it reads an operation code, two register operands, a sign-extended immediate and the address of the current instruction. It computes an arithmetic, logical, compare or shift result, or it resolves a control transfer. One clock later it presents the result, the forwarded operation code and a token for the memory stage. Every register-register operation has an immediate twin that takes the immediate in place of the second operand. Load and store addresses come from the add path.

Control transfers are relative to the current instruction address. The unit forms the target and raises the fetch redirect itself, so a taken branch needs no other stage. An end operation latches a halt flag. A division by zero gives an all-ones quotient and sets a sticky error flag instead of trapping. Hazards, forwarding and data memory belong to other blocks.

Top module: `xs_alu_stage`

## Requirements
- R1: Codes 0..5 are add, addi, sub, subi, mul, muli. Odd codes from 1 to 21 are immediate forms that take `imm_i` as the second operand, and even codes take `opb_i`. A multiply returns the low 32 bits of the product.
- R2: Codes 6 (div) and 7 (divi) give a signed quotient truncated toward zero. Dividing the most negative value by -1 gives the most negative value. A zero divisor gives all ones and sets `div_err_o`, which stays set until reset.
- R3: Codes 8..13 are and, andi, or, ori, xor, xori, applied bitwise.
- R4: Codes 14 (slt) and 15 (slti) give 1 when the first operand is less than the second under a signed two's-complement compare, and 0 otherwise.
- R5: Codes 16..21 are sll, slli, srl, srli, sra, srai. Only the low 5 bits of the shift operand count. srl/srli fill with zeros, and sra/srai copy the sign bit.
- R6: Codes 22 (load) and 23 (store) give `opa_i + imm_i` as the address result.
- R7: Codes 25 (beq), 26 (bne), 27 (blt) and 28 (bgt) compare `opa_i` with `opb_i` as signed values. When the condition holds, `redir_vld_o` pulses with `redir_pc_o = pc_i + imm_i`, and that target is also the result. When it fails there is no redirect and the result is 0.
- R8: Code 24 (jmp) always redirects to `pc_i` plus an offset. The offset is `opa_i` when `jreg_i` is 1 and `imm_i` when it is 0. The target is also the result.
- R9: Code 29 (end) sets `halt_o`, which stays set until reset. Codes 29, 30 and 31 give result 0 and no redirect.
- R10: `tok_take_o` equals `en_i` in the same cycle. The clock edge that samples `en_i` = 1 updates `result_o`, forwards the code to `op_o`, and makes `mem_tok_o` high for exactly the next cycle.
- R11: After a cycle with `en_i` = 0, `mem_tok_o` and `redir_vld_o` are 0, and `result_o` and `op_o` keep their values.
- R12: Reset (`rst_n` low, asynchronous) clears every output register, including `halt_o` and `div_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Execute token from operand fetch |
| op_i | input | 5 | Operation code |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 32 | Sign-extended immediate |
| pc_i | input | 32 | Address of the current instruction |
| jreg_i | input | 1 | jmp offset comes from `opa_i` |
| tok_take_o | output | 1 | Clears the upstream token |
| mem_tok_o | output | 1 | Token to the memory stage |
| op_o | output | 5 | Forwarded operation code |
| result_o | output | 32 | ALU result, address or target |
| redir_vld_o | output | 1 | Fetch redirect pulse |
| redir_pc_o | output | 32 | Redirect target |
| halt_o | output | 1 | Sticky halt |
| div_err_o | output | 1 | Sticky divide-by-zero flag |

## Verification
The bench targets the places where signedness matters:
- A unit that uses an unsigned compare would take blt with -1 against 1 the wrong way and would report slt as 0.
- A logical right shift in place of sra would lose the sign fill.
- A divider that rounds toward minus infinity would give -4 for -7/2.

It also uses a shift amount of 33 and of 32 to catch a unit that reads more than five bits of the shift operand. A divide by zero checks for all ones and then checks that the error flag survives a later good divide. The most-negative-by-minus-one quotient checks the wraparound. A register-offset jmp checks that the offset comes from the operand and not the immediate. Idle cycles check that a unit with a free-running token or redirect would be caught.

// File: rtl/xs_pkg.sv
package xs_pkg;

  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_ADDI = 5'd1,  OP_SUB  = 5'd2,  OP_SUBI = 5'd3,
    OP_MUL  = 5'd4,  OP_MULI = 5'd5,  OP_DIV  = 5'd6,  OP_DIVI = 5'd7,
    OP_AND  = 5'd8,  OP_ANDI = 5'd9,  OP_OR   = 5'd10, OP_ORI  = 5'd11,
    OP_XOR  = 5'd12, OP_XORI = 5'd13, OP_SLT  = 5'd14, OP_SLTI = 5'd15,
    OP_SLL  = 5'd16, OP_SLLI = 5'd17, OP_SRL  = 5'd18, OP_SRLI = 5'd19,
    OP_SRA  = 5'd20, OP_SRAI = 5'd21, OP_LD   = 5'd22, OP_ST   = 5'd23,
    OP_JMP  = 5'd24, OP_BEQ  = 5'd25, OP_BNE  = 5'd26, OP_BLT  = 5'd27,
    OP_BGT  = 5'd28, OP_END  = 5'd29, OP_RSV0 = 5'd30, OP_RSV1 = 5'd31
  } op_e;

  typedef enum logic [1:0] {U_NONE, U_ARITH, U_LOGIC, U_CTRL} unit_e;

  // Which datapath answers for a given code
  function automatic unit_e f_unit(input op_e op);
    unit_e u;
    case (op)
      OP_ADD, OP_ADDI, OP_SUB, OP_SUBI, OP_MUL, OP_MULI,
      OP_DIV, OP_DIVI, OP_LD, OP_ST:                    u = U_ARITH;
      OP_AND, OP_ANDI, OP_OR, OP_ORI, OP_XOR, OP_XORI,
      OP_SLT, OP_SLTI, OP_SLL, OP_SLLI, OP_SRL, OP_SRLI,
      OP_SRA, OP_SRAI:                                  u = U_LOGIC;
      OP_JMP, OP_BEQ, OP_BNE, OP_BLT, OP_BGT:           u = U_CTRL;
      default:                                          u = U_NONE;
    endcase
    return u;
  endfunction

  // Second operand comes from the immediate
  function automatic logic f_uses_imm(input op_e op);
    return ((op <= OP_SRAI) && op[0]) || (op == OP_LD) || (op == OP_ST);
  endfunction

endpackage

// File: rtl/xs_arith.sv
module xs_arith
  import xs_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         div_zero
);

  // Signed quotient, truncated toward zero; zero divisor yields all ones
  function automatic logic [W-1:0] f_quot(input logic [W-1:0] n, input logic [W-1:0] d);
    logic [W-1:0] un;
    logic [W-1:0] ud;
    logic [W-1:0] uq;
    logic         neg;
    if (d == '0) return '1;
    neg = n[W-1] ^ d[W-1];
    un  = n[W-1] ? (~n + 1'b1) : n;
    ud  = d[W-1] ? (~d + 1'b1) : d;
    uq  = un / ud;
    return neg ? (~uq + 1'b1) : uq;
  endfunction

  function automatic logic [W-1:0] f_mul_lo(input logic [W-1:0] x, input logic [W-1:0] y);
    return x * y;
  endfunction

  always_comb begin
    case (op)
      OP_ADD, OP_ADDI, OP_LD, OP_ST: res = a + b;
      OP_SUB, OP_SUBI:               res = a - b;
      OP_MUL, OP_MULI:               res = f_mul_lo(a, b);
      OP_DIV, OP_DIVI:               res = f_quot(a, b);
      default:                       res = '0;
    endcase
  end

  assign div_zero = ((op == OP_DIV) || (op == OP_DIVI)) && (b == '0);

endmodule

// File: rtl/xs_logic.sv
module xs_logic
  import xs_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);

  localparam int SHW = $clog2(W);

  function automatic logic [W-1:0] f_slt(input logic [W-1:0] x, input logic [W-1:0] y);
    return ($signed(x) < $signed(y)) ? W'(1) : '0;
  endfunction

  function automatic logic [W-1:0] f_sra(input logic [W-1:0] x, input logic [SHW-1:0] s);
    return W'($signed(x) >>> s);
  endfunction

  logic [SHW-1:0] sh;
  assign sh = b[SHW-1:0];

  always_comb begin
    case (op)
      OP_AND, OP_ANDI: res = a & b;
      OP_OR,  OP_ORI:  res = a | b;
      OP_XOR, OP_XORI: res = a ^ b;
      OP_SLT, OP_SLTI: res = f_slt(a, b);
      OP_SLL, OP_SLLI: res = a << sh;
      OP_SRL, OP_SRLI: res = a >> sh;
      OP_SRA, OP_SRAI: res = f_sra(a, sh);
      default:         res = '0;
    endcase
  end

endmodule

// File: rtl/xs_branch.sv
module xs_branch
  import xs_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] pc,
  input  logic         jreg,
  output logic         take,
  output logic [W-1:0] target
);

  function automatic logic f_cond(input op_e o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic c;
    case (o)
      OP_JMP:  c = 1'b1;
      OP_BEQ:  c = (x == y);
      OP_BNE:  c = (x != y);
      OP_BLT:  c = ($signed(x) < $signed(y));
      OP_BGT:  c = ($signed(x) > $signed(y));
      default: c = 1'b0;
    endcase
    return c;
  endfunction

  logic [W-1:0] offset;
  assign offset = ((op == OP_JMP) && jreg) ? a : imm;
  assign target = pc + offset;
  assign take   = f_cond(op, a, b);

endmodule

// File: rtl/xs_alu_stage.sv
module xs_alu_stage
  import xs_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   opa_i,
  input  logic [W-1:0]   opb_i,
  input  logic [W-1:0]   imm_i,
  input  logic [W-1:0]   pc_i,
  input  logic           jreg_i,
  output logic           tok_take_o,
  output logic           mem_tok_o,
  output logic [OPW-1:0] op_o,
  output logic [W-1:0]   result_o,
  output logic           redir_vld_o,
  output logic [W-1:0]   redir_pc_o,
  output logic           halt_o,
  output logic           div_err_o
);

  op_e          op;
  logic [W-1:0] b_eff;
  logic [W-1:0] ar_res;
  logic [W-1:0] lg_res;
  logic [W-1:0] br_tgt;
  logic         br_take;
  logic         div_zero;
  logic         is_end;
  logic [W-1:0] sel_res;

  assign op      = op_e'(op_i);
  assign b_eff   = f_uses_imm(op) ? imm_i : opb_i;
  assign is_end  = (op == OP_END);

  xs_arith #(.W(W)) i_arith (
    .op(op), .a(opa_i), .b(b_eff), .res(ar_res), .div_zero(div_zero)
  );

  xs_logic #(.W(W)) i_logic (
    .op(op), .a(opa_i), .b(b_eff), .res(lg_res)
  );

  xs_branch #(.W(W)) i_branch (
    .op(op), .a(opa_i), .b(opb_i), .imm(imm_i), .pc(pc_i), .jreg(jreg_i),
    .take(br_take), .target(br_tgt)
  );

  always_comb begin
    case (f_unit(op))
      U_ARITH: sel_res = ar_res;
      U_LOGIC: sel_res = lg_res;
      U_CTRL:  sel_res = br_take ? br_tgt : '0;
      default: sel_res = '0;
    endcase
  end

  assign tok_take_o = en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_tok_o   <= 1'b0;
      op_o        <= '0;
      result_o    <= '0;
      redir_vld_o <= 1'b0;
      redir_pc_o  <= '0;
      halt_o      <= 1'b0;
      div_err_o   <= 1'b0;
    end else begin
      mem_tok_o   <= en_i;
      redir_vld_o <= en_i && br_take;
      if (en_i) begin
        result_o <= sel_res;
        op_o     <= op_i;
        if (br_take) redir_pc_o <= br_tgt;
        if (div_zero) div_err_o <= 1'b1;
        if (is_end)   halt_o    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/xs_alu_chk.sv
module xs_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_i,
  input logic [4:0]   op_i,
  input logic [W-1:0] imm_i,
  input logic [W-1:0] pc_i,
  input logic         jreg_i,
  input logic         mem_tok_o,
  input logic [4:0]   op_o,
  input logic [W-1:0] result_o,
  input logic         redir_vld_o,
  input logic [W-1:0] redir_pc_o,
  input logic         halt_o,
  input logic         div_err_o,
  input logic         br_take,
  input logic         div_zero
);

  a_r10_token_follows: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> mem_tok_o);

  a_r10_op_forward: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (op_o == $past(op_i)));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!mem_tok_o && !redir_vld_o && $stable(result_o) && $stable(op_o)));

  a_r8_jmp_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && op_i == 5'd24) |=> redir_vld_o);

  a_r7_imm_target: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && br_take && !(op_i == 5'd24 && jreg_i)) |=>
      (redir_pc_o == $past(pc_i) + $past(imm_i)));

  a_r7_redir_only_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld_o |-> (op_o >= 5'd24 && op_o <= 5'd28));

  a_r2_div_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && div_zero) |=> div_err_o);

  a_r2_div_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    div_err_o |=> div_err_o);

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> halt_o);

endmodule

bind xs_alu_stage xs_alu_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .imm_i(imm_i),
  .pc_i(pc_i), .jreg_i(jreg_i), .mem_tok_o(mem_tok_o), .op_o(op_o),
  .result_o(result_o), .redir_vld_o(redir_vld_o), .redir_pc_o(redir_pc_o),
  .halt_o(halt_o), .div_err_o(div_err_o), .br_take(br_take),
  .div_zero(div_zero)
);

// File: tb/test_xs_alu_stage.sv
module test_xs_alu_stage;

  typedef struct packed {
    logic [4:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] imm;
    logic [31:0] pc;
    logic        jr;
    logic [31:0] res;
    logic        rv;
    logic [31:0] rpc;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VT [NV] = '{
    '{5'd0,  32'd5,        32'd7,        32'd0,        32'h100, 1'b0, 32'd12,       1'b0, 32'd0},
    '{5'd1,  32'd5,        32'd99,       32'hFFFFFFFF, 32'h100, 1'b0, 32'd4,        1'b0, 32'd0},
    '{5'd2,  32'd3,        32'd5,        32'd0,        32'h100, 1'b0, 32'hFFFFFFFE, 1'b0, 32'd0},
    '{5'd3,  32'd10,       32'd99,       32'd3,        32'h100, 1'b0, 32'd7,        1'b0, 32'd0},
    '{5'd4,  32'hFFFFFFFD, 32'd7,        32'd0,        32'h100, 1'b0, 32'hFFFFFFEB, 1'b0, 32'd0},
    '{5'd5,  32'h10000,    32'd1,        32'h10000,    32'h100, 1'b0, 32'd0,        1'b0, 32'd0},
    '{5'd6,  32'hFFFFFFF9, 32'd2,        32'd0,        32'h100, 1'b0, 32'hFFFFFFFD, 1'b0, 32'd0},
    '{5'd7,  32'd7,        32'd0,        32'hFFFFFFFE, 32'h100, 1'b0, 32'hFFFFFFFD, 1'b0, 32'd0},
    '{5'd8,  32'hF0F0F0F0, 32'hFF00FF00, 32'd0,        32'h100, 1'b0, 32'hF000F000, 1'b0, 32'd0},
    '{5'd9,  32'h12345678, 32'd0,        32'hFF,       32'h100, 1'b0, 32'h78,       1'b0, 32'd0},
    '{5'd10, 32'hF0,       32'h0F,       32'd0,        32'h100, 1'b0, 32'hFF,       1'b0, 32'd0},
    '{5'd11, 32'h100,      32'd0,        32'd1,        32'h100, 1'b0, 32'h101,      1'b0, 32'd0},
    '{5'd12, 32'hFF,       32'h0F,       32'd0,        32'h100, 1'b0, 32'hF0,       1'b0, 32'd0},
    '{5'd13, 32'hAAAAAAAA, 32'd0,        32'hFFFFFFFF, 32'h100, 1'b0, 32'h55555555, 1'b0, 32'd0},
    '{5'd14, 32'hFFFFFFFF, 32'd1,        32'd0,        32'h100, 1'b0, 32'd1,        1'b0, 32'd0},
    '{5'd15, 32'd1,        32'd5,        32'hFFFFFFFF, 32'h100, 1'b0, 32'd0,        1'b0, 32'd0},
    '{5'd16, 32'd1,        32'd33,       32'd0,        32'h100, 1'b0, 32'd2,        1'b0, 32'd0},
    '{5'd17, 32'd3,        32'd0,        32'd4,        32'h100, 1'b0, 32'h30,       1'b0, 32'd0},
    '{5'd18, 32'h80000000, 32'd4,        32'd0,        32'h100, 1'b0, 32'h08000000, 1'b0, 32'd0},
    '{5'd19, 32'hFFFFFFFF, 32'd0,        32'd31,       32'h100, 1'b0, 32'd1,        1'b0, 32'd0},
    '{5'd20, 32'h80000000, 32'd4,        32'd0,        32'h100, 1'b0, 32'hF8000000, 1'b0, 32'd0},
    '{5'd21, 32'h40000000, 32'd0,        32'd32,       32'h100, 1'b0, 32'h40000000, 1'b0, 32'd0},
    '{5'd22, 32'h1000,     32'd0,        32'hFFFFFFFC, 32'h100, 1'b0, 32'hFFC,      1'b0, 32'd0},
    '{5'd23, 32'h20,       32'd0,        32'd8,        32'h100, 1'b0, 32'h28,       1'b0, 32'd0},
    '{5'd24, 32'd0,        32'd0,        32'h40,       32'h100, 1'b0, 32'h140,      1'b1, 32'h140},
    '{5'd24, 32'hFFFFFFF0, 32'd0,        32'h40,       32'h100, 1'b1, 32'hF0,       1'b1, 32'hF0},
    '{5'd25, 32'd5,        32'd5,        32'h10,       32'h200, 1'b0, 32'h210,      1'b1, 32'h210},
    '{5'd25, 32'd5,        32'd6,        32'h10,       32'h200, 1'b0, 32'd0,        1'b0, 32'd0},
    '{5'd26, 32'd5,        32'd6,        32'hFFFFFFF8, 32'h200, 1'b0, 32'h1F8,      1'b1, 32'h1F8},
    '{5'd27, 32'hFFFFFFFF, 32'd1,        32'd4,        32'h300, 1'b0, 32'h304,      1'b1, 32'h304},
    '{5'd28, 32'hFFFFFFFF, 32'd1,        32'd8,        32'h300, 1'b0, 32'd0,        1'b0, 32'd0},
    '{5'd28, 32'd2,        32'd1,        32'd8,        32'h300, 1'b0, 32'h308,      1'b1, 32'h308}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [31:0] opa_i = '0, opb_i = '0, imm_i = '0, pc_i = '0;
  logic        jreg_i = 1'b0;
  logic        tok_take_o, mem_tok_o, redir_vld_o, halt_o, div_err_o;
  logic [4:0]  op_o;
  logic [31:0] result_o, redir_pc_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xs_alu_stage i_xs_alu_stage (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .opa_i(opa_i),
    .opb_i(opb_i), .imm_i(imm_i), .pc_i(pc_i), .jreg_i(jreg_i),
    .tok_take_o(tok_take_o), .mem_tok_o(mem_tok_o), .op_o(op_o),
    .result_o(result_o), .redir_vld_o(redir_vld_o), .redir_pc_o(redir_pc_o),
    .halt_o(halt_o), .div_err_o(div_err_o)
  );

  function automatic string req_of(input logic [4:0] op);
    if (op <= 5'd5)  return "R1";
    if (op <= 5'd7)  return "R2";
    if (op <= 5'd13) return "R3";
    if (op <= 5'd15) return "R4";
    if (op <= 5'd21) return "R5";
    if (op <= 5'd23) return "R6";
    if (op == 5'd24) return "R8";
    if (op <= 5'd28) return "R7";
    return "R9";
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one enabled cycle; return at the negedge after the capturing edge
  task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] imm, input logic [31:0] pc, input logic jr);
    @(negedge clk);
    op_i = op; opa_i = a; opb_i = b; imm_i = imm; pc_i = pc; jreg_i = jr; en_i = 1'b1;
    #1 chk("R10", "tok_take_o while enabled", 32'(tok_take_o), 32'd1);
    @(negedge clk);
    en_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "result_o in reset", result_o, 32'd0);
    chk("R12", "mem_tok_o in reset", 32'(mem_tok_o), 32'd0);
    chk("R12", "redir_vld_o in reset", 32'(redir_vld_o), 32'd0);
    chk("R12", "halt_o in reset", 32'(halt_o), 32'd0);
    chk("R12", "div_err_o in reset", 32'(div_err_o), 32'd0);
    chk("R10", "tok_take_o idle", 32'(tok_take_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VT[i].op, VT[i].a, VT[i].b, VT[i].imm, VT[i].pc, VT[i].jr);
      chk(req_of(VT[i].op), $sformatf("result v%0d", i), result_o, VT[i].res);
      chk(req_of(VT[i].op), $sformatf("redirect v%0d", i), 32'(redir_vld_o), 32'(VT[i].rv));
      if (VT[i].rv) chk(req_of(VT[i].op), $sformatf("target v%0d", i), redir_pc_o, VT[i].rpc);
      chk("R10", $sformatf("mem token v%0d", i), 32'(mem_tok_o), 32'd1);
      chk("R10", $sformatf("op forward v%0d", i), 32'(op_o), 32'(VT[i].op));
    end

    chk("R2", "no divide error yet", 32'(div_err_o), 32'd0);

    // R11 idle cycle holds state, no token, no redirect
    held = result_o;
    @(negedge clk);
    chk("R11", "mem token after idle", 32'(mem_tok_o), 32'd0);
    chk("R11", "redirect after idle", 32'(redir_vld_o), 32'd0);
    chk("R11", "result held", result_o, held);
    chk("R11", "op held", 32'(op_o), 32'd28);

    // R2 divide by zero and sticky flag
    apply(5'd6, 32'd9, 32'd0, 32'd0, 32'h100, 1'b0);
    chk("R2", "div by zero result", result_o, 32'hFFFFFFFF);
    chk("R2", "div error set", 32'(div_err_o), 32'd1);
    apply(5'd6, 32'd9, 32'd3, 32'd0, 32'h100, 1'b0);
    chk("R2", "good div after error", result_o, 32'd3);
    chk("R2", "div error sticky", 32'(div_err_o), 32'd1);
    apply(5'd7, 32'h80000000, 32'd0, 32'hFFFFFFFF, 32'h100, 1'b0);
    chk("R2", "min by minus one", result_o, 32'h80000000);

    // R9 unused codes and end
    apply(5'd30, 32'd5, 32'd5, 32'd4, 32'h100, 1'b0);
    chk("R9", "reserved code result", result_o, 32'd0);
    chk("R9", "reserved code no redirect", 32'(redir_vld_o), 32'd0);
    chk("R9", "reserved code no halt", 32'(halt_o), 32'd0);
    apply(5'd29, 32'd5, 32'd5, 32'd4, 32'h100, 1'b0);
    chk("R9", "end sets halt", 32'(halt_o), 32'd1);
    chk("R9", "end result", result_o, 32'd0);
    apply(5'd0, 32'd1, 32'd1, 32'd0, 32'h100, 1'b0);
    chk("R9", "halt sticky", 32'(halt_o), 32'd1);
    chk("R1", "add after end", result_o, 32'd2);

    // R12 reset clears sticky flags
    rst_n = 1'b0;
    #1;
    chk("R12", "halt cleared", 32'(halt_o), 32'd0);
    chk("R12", "div error cleared", 32'(div_err_o), 32'd0);
    chk("R12", "result cleared", result_o, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule